// File: doc/BRIEF.md
# Configurable SPI Master Shift Engine

This block is the serial core of an SPI master. It takes 32-bit words from a transmit queue and shifts each one out on a serial data line, most significant bit first. At the same time it shifts the same number of bits in from the slave and hands every received word to a receive queue. The word length is programmable from 4 to 32 bits. The serial clock is made by dividing the core clock, and its idle level can be set low or high. A phase control chooses whether a bit is sampled on the leading clock edge or on the trailing one. An internal loopback path feeds the transmit line straight back into the receiver.

A transfer begins with a start pulse and a word count. The engine runs that many words and then stops with a single done pulse. Each transmit word is taken from the top bits of its 32-bit entry, so a byte-packed word begins at bit 31. Each received word is returned right-justified with zeros above it. If the transmit queue is empty when a word is due to begin, the engine waits with the serial clock held at its idle level. It sends no undefined data.

The four chip-select lines run in one of two ways. In forced mode software drives each line from its own assert bit. In automatic mode the line picked by a 2-bit select field goes low for as long as a transfer is active.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset, busy, done and rxValid are 0, the serial clock sits at the level set by sclkIdleHigh, and with csForce=0 every chip-select line is high.
- R2: cfgLenM1 holds the word length minus one, so a word has L = cfgLenM1+1 bits, and the legal values give L from 4 to 32. Each received word appears on rxData in bits L-1:0 with every higher bit 0.
- R3: The transmit word comes from txData bits 31 down to 32-L. It is sent on spiMosi most significant bit first.
- R4: With cfgInputFirst=1, the first bit is on spiMosi before the first clock edge, the slave samples on leading (away-from-idle) edges, and spiMosi changes on trailing edges. With cfgInputFirst=0, spiMosi changes on leading edges and sampling happens on trailing edges.
- R5: When sclkIdleHigh=1 the serial clock idles high, so leading edges fall. When sclkIdleHigh=0 it idles low.
- R6: With cfgLoopback=1, the received word equals the transmitted bits and spiMiso has no effect.
- R7: With csForce=1 and csAuto=0, spiCsN[i] equals the inverse of csAssert[i], both while idle and while busy.
- R8: Otherwise, the line numbered csSel is low while busy and every other line is high. When not busy, all lines are high.
- R9: A start pulse with wordCount=N>0, given while idle, transfers exactly N words. After the last word the block gives one done pulse, in the same cycle as the last rxValid, and busy is 0. A start with wordCount=0 is ignored.
- R10: If txValid is low when a word is due to begin, no clock edge occurs and the clock holds its idle level. Shifting resumes once a word arrives.
- R11: Consecutive serial clock edges inside a word are clkDiv+1 core cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgLenM1 | input | 5 | Word length minus one |
| cfgInputFirst | input | 1 | 1: sample on leading edge; 0: sample on trailing edge |
| cfgLoopback | input | 1 | Route transmit data into the receiver |
| sclkIdleHigh | input | 1 | Serial clock idle level |
| csForce | input | 1 | Manual chip-select control |
| csAuto | input | 1 | Automatic chip-select mode; overrides csForce |
| csSel | input | 2 | Line asserted in automatic mode |
| csAssert | input | 4 | Per-line assert bits in forced mode |
| clkDiv | input | 8 | Half period of the serial clock minus one, in core cycles |
| wordCount | input | 16 | Words to transfer |
| start | input | 1 | Start pulse |
| busy | output | 1 | Transfer active |
| done | output | 1 | One-cycle pulse after the last word |
| txData | input | 32 | Transmit queue head, MSB-aligned |
| txValid | input | 1 | Transmit queue not empty |
| txReady | output | 1 | Pops the transmit queue head |
| rxData | output | 32 | Received word, right-justified |
| rxValid | output | 1 | Pushes rxData into the receive queue |
| spiSclk | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data out |
| spiMiso | input | 1 | Serial data in |
| spiCsN | output | 4 | Active-low chip selects |

## Verification
A wrong edge counter shows at the ports within one word. The bench's slave model catches a word that is too long or too short, or a bit sampled on the wrong edge, and the right-justification assertion fires on the first received word that has bits above its length. A word counter that is off by one makes done arrive one word early or late. A stall that lets edges leak out moves the serial clock away from idle during the forty-cycle wait, and the bench samples that wait directly.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int WORD_W   = 32;
  localparam int LEN_W    = 5;
  localparam int CS_COUNT = 4;
  localparam int SEL_W    = $clog2(CS_COUNT);

  typedef struct packed {
    logic load;     // take a new word from the transmit queue
    logic lead;     // leading serial clock edge
    logic trail;    // trailing serial clock edge
    logic wordEnd;  // trailing edge that closes the word
  } eng_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SHIFT = 2'd2
  } eng_state_e;
endpackage

// File: rtl/spi_eng_ctrl.sv
module spi_eng_ctrl
  import spi_eng_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] wordCount,
  input  logic [LEN_W-1:0] lenM1,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             txValid,
  output eng_strobe_t      str,
  output logic             busy,
  output logic             done,
  output logic             txReady
);
  localparam int EDGE_W = LEN_W + 1;

  eng_state_e       state;
  logic [DIV_W-1:0] divCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic [CNT_W-1:0] remaining;
  logic [EDGE_W-1:0] lastEdge;
  logic             tick;
  logic             doneQ;

  assign lastEdge = {lenM1, 1'b1};
  assign tick     = (state == ST_SHIFT) && (divCnt == clkDiv);

  always_comb begin
    str.load    = (state == ST_FETCH) && txValid;
    str.lead    = tick && !edgeCnt[0];
    str.trail   = tick && edgeCnt[0];
    str.wordEnd = tick && edgeCnt[0] && (edgeCnt == lastEdge);
  end

  assign busy    = (state != ST_IDLE);
  assign done    = doneQ;
  assign txReady = str.load;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      divCnt    <= '0;
      edgeCnt   <= '0;
      remaining <= '0;
      doneQ     <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start && (wordCount != '0)) begin
            remaining <= wordCount;
            state     <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (txValid) begin
            state   <= ST_SHIFT;
            divCnt  <= '0;
            edgeCnt <= '0;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            divCnt <= '0;
            if (edgeCnt == lastEdge) begin
              remaining <= remaining - CNT_W'(1);
              if (remaining == CNT_W'(1)) begin
                state <= ST_IDLE;
                doneQ <= 1'b1;
              end else begin
                state <= ST_FETCH;
              end
            end else begin
              edgeCnt <= edgeCnt + EDGE_W'(1);
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ACTIVE_HAS_WORDS: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> (remaining != '0)); // R9

  AST_EDGE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT) |-> (edgeCnt <= lastEdge)); // R2
endmodule

// File: rtl/spi_eng_dp.sv
module spi_eng_dp
  import spi_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  eng_strobe_t       str,
  input  logic [LEN_W-1:0]  lenM1,
  input  logic              inputFirst,
  input  logic              loopback,
  input  logic              idleHigh,
  input  logic [WORD_W-1:0] txData,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [WORD_W-1:0] rxData,
  output logic              rxValid
);
  logic [WORD_W-1:0] txSh;
  logic [WORD_W-1:0] rxSh;
  logic [WORD_W-1:0] rxNext;
  logic              mosiQ;
  logic              phase;
  logic              inBit;

  assign inBit  = loopback ? mosiQ : miso;
  assign rxNext = {rxSh[WORD_W-2:0], inBit};
  assign sclk   = idleHigh ^ phase;
  assign mosi   = mosiQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh    <= '0;
      rxSh    <= '0;
      mosiQ   <= 1'b0;
      phase   <= 1'b0;
      rxData  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (str.load) begin
        rxSh <= '0;
        if (inputFirst) begin
          mosiQ <= txData[WORD_W-1];
          txSh  <= {txData[WORD_W-2:0], 1'b0};
        end else begin
          txSh  <= txData;
        end
      end
      if (str.lead) begin
        phase <= 1'b1;
        if (inputFirst) begin
          rxSh <= rxNext;
        end else begin
          mosiQ <= txSh[WORD_W-1];
          txSh  <= {txSh[WORD_W-2:0], 1'b0};
        end
      end
      if (str.trail) begin
        phase <= 1'b0;
        if (!inputFirst) begin
          rxSh <= rxNext;
        end else if (!str.wordEnd) begin
          mosiQ <= txSh[WORD_W-1];
          txSh  <= {txSh[WORD_W-2:0], 1'b0};
        end
      end
      if (str.wordEnd) begin
        rxData  <= inputFirst ? rxSh : rxNext;
        rxValid <= 1'b1;
      end
    end
  end

  AST_CLOCK_HOLDS_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    !(str.lead || str.trail) |=> $stable(phase)); // R10

  AST_RX_RIGHT_JUSTIFIED: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> (((rxData >> lenM1) >> 1) == '0)); // R2
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_eng_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [LEN_W-1:0]    cfgLenM1,
  input  logic                cfgInputFirst,
  input  logic                cfgLoopback,
  input  logic                sclkIdleHigh,
  input  logic                csForce,
  input  logic                csAuto,
  input  logic [SEL_W-1:0]    csSel,
  input  logic [CS_COUNT-1:0] csAssert,
  input  logic [DIV_W-1:0]    clkDiv,
  input  logic [CNT_W-1:0]    wordCount,
  input  logic                start,
  output logic                busy,
  output logic                done,
  input  logic [WORD_W-1:0]   txData,
  input  logic                txValid,
  output logic                txReady,
  output logic [WORD_W-1:0]   rxData,
  output logic                rxValid,
  output logic                spiSclk,
  output logic                spiMosi,
  input  logic                spiMiso,
  output logic [CS_COUNT-1:0] spiCsN
);
  eng_strobe_t str;
  logic        manualCs;

  spi_eng_ctrl #(.DIV_W(DIV_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .wordCount(wordCount),
    .lenM1(cfgLenM1), .clkDiv(clkDiv), .txValid(txValid),
    .str(str), .busy(busy), .done(done), .txReady(txReady)
  );

  spi_eng_dp dp_i (
    .clk(clk), .rstN(rstN), .str(str), .lenM1(cfgLenM1),
    .inputFirst(cfgInputFirst), .loopback(cfgLoopback), .idleHigh(sclkIdleHigh),
    .txData(txData), .miso(spiMiso), .sclk(spiSclk), .mosi(spiMosi),
    .rxData(rxData), .rxValid(rxValid)
  );

  assign manualCs = csForce && !csAuto;

  for (genvar i = 0; i < CS_COUNT; i++) begin : g_cs
    assign spiCsN[i] = manualCs ? !csAssert[i]
                                : !(busy && (csSel == SEL_W'(i)));
  end

  AST_DONE_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R9

  AST_RX_AFTER_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(busy)); // R9

  AST_SCLK_AT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (spiSclk == sclkIdleHigh)); // R5
endmodule

// File: tb/spi_shift_engine_tb.sv
module spi_shift_engine_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  cfgLenM1 = 5'd7;
  logic        cfgInputFirst = 1'b1;
  logic        cfgLoopback = 1'b0;
  logic        sclkIdleHigh = 1'b0;
  logic        csForce = 1'b0;
  logic        csAuto = 1'b0;
  logic [1:0]  csSel = 2'd0;
  logic [3:0]  csAssert = 4'd0;
  logic [7:0]  clkDiv = 8'd1;
  logic [15:0] wordCount = 16'd0;
  logic        start = 1'b0;
  logic        busy, done, txReady, rxValid, spiSclk, spiMosi, spiMiso;
  logic [31:0] txData, rxData;
  logic        txValid;
  logic [3:0]  spiCsN;

  always #5 clk = ~clk;

  spi_shift_engine dut_i (
    .clk(clk), .rstN(rstN), .cfgLenM1(cfgLenM1), .cfgInputFirst(cfgInputFirst),
    .cfgLoopback(cfgLoopback), .sclkIdleHigh(sclkIdleHigh), .csForce(csForce),
    .csAuto(csAuto), .csSel(csSel), .csAssert(csAssert), .clkDiv(clkDiv),
    .wordCount(wordCount), .start(start), .busy(busy), .done(done),
    .txData(txData), .txValid(txValid), .txReady(txReady), .rxData(rxData),
    .rxValid(rxValid), .spiSclk(spiSclk), .spiMosi(spiMosi), .spiMiso(spiMiso),
    .spiCsN(spiCsN)
  );

  int errors = 0;
  int checks = 0;

  // transmit queue model
  logic [31:0] txMem [4];
  int txPops = 0;
  int txAvail = 0;
  assign txValid = (txPops < txAvail);
  assign txData  = txMem[txPops & 3];
  always @(posedge clk) if (txValid && txReady) txPops <= txPops + 1;

  // slave model and monitor
  int          benchLen = 8;
  logic        benchFirst = 1'b1;
  logic        benchIdle = 1'b0;
  logic [31:0] slaveWord = '0;
  logic [31:0] slvShift = '0;
  int          slvCnt = 0;
  logic [31:0] mosiLog [4];
  logic [31:0] rxLog [4];
  int          mosiN = 0, rxN = 0, doneN = 0, edgeN = 0, e1 = 0, e2 = 0, cyc = 0;
  logic        prevSclk = 1'b0;

  assign spiMiso = (slvCnt < benchLen) ? slaveWord[benchLen-1-slvCnt] : 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if ((spiSclk !== prevSclk) && (busy || done)) begin
      logic leadE, sampE;
      leadE = (spiSclk != benchIdle);
      sampE = benchFirst ? leadE : !leadE;
      edgeN = edgeN + 1;
      if (edgeN == 1) e1 = cyc;
      if (edgeN == 2) e2 = cyc;
      if (sampE) begin
        slvShift = {slvShift[30:0], spiMosi};
        slvCnt = slvCnt + 1;
        if (slvCnt == benchLen) begin
          mosiLog[mosiN & 3] = slvShift;
          mosiN = mosiN + 1;
          slvCnt = 0;
          slvShift = '0;
        end
      end
    end
    prevSclk = spiSclk;
    if (rxValid) begin
      rxLog[rxN & 3] = rxData;
      rxN = rxN + 1;
    end
    if (done) doneN = doneN + 1;
  end

  always @(negedge clk) begin
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] topBits(input logic [31:0] w, input int len);
    return (len == 32) ? w : (w >> (32 - len));
  endfunction

  function automatic logic [31:0] lowBits(input logic [31:0] w, input int len);
    return (len == 32) ? w : (w & ((32'd1 << len) - 32'd1));
  endfunction

  task automatic clearLogs();
    mosiN = 0; rxN = 0; doneN = 0; edgeN = 0; slvCnt = 0; slvShift = '0;
  endtask

  task automatic setCfg(input int lenM1, input bit first, input bit idle, input bit lb);
    @(negedge clk);
    cfgLenM1 = 5'(lenM1); cfgInputFirst = first; sclkIdleHigh = idle; cfgLoopback = lb;
    benchLen = lenM1 + 1; benchFirst = first; benchIdle = idle;
    @(negedge clk);
    clearLogs();
  endtask

  task automatic kick(input int n);
    @(negedge clk);
    wordCount = 16'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(input string req);
    int i;
    for (i = 0; i < 20000; i++) begin
      if (doneN > 0) break;
      @(negedge clk);
    end
    chk(doneN > 0, req, 32'(doneN), 32'd1);
  endtask

  // {lenM1[4:0], inputFirst, idleHigh, loopback, tx[31:0], miso[31:0]}
  localparam logic [71:0] VEC [9] = '{
    {5'd7,  1'b1, 1'b0, 1'b0, 32'hA500_0000, 32'h0000_003C},
    {5'd7,  1'b0, 1'b0, 1'b0, 32'h5A00_0000, 32'h0000_00C3},
    {5'd15, 1'b1, 1'b1, 1'b0, 32'h1234_FFFF, 32'h0000_BEEF},
    {5'd15, 1'b0, 1'b1, 1'b0, 32'hCAFE_0000, 32'hFFFF_8001},
    {5'd3,  1'b1, 1'b0, 1'b1, 32'h9FFF_FFFF, 32'h0000_0006},
    {5'd31, 1'b0, 1'b0, 1'b0, 32'hDEAD_BEEF, 32'h1357_2468},
    {5'd31, 1'b1, 1'b1, 1'b1, 32'h8000_0001, 32'h0000_0000},
    {5'd11, 1'b0, 1'b1, 1'b1, 32'hABC1_2345, 32'hFFFF_FFFF},
    {5'd4,  1'b1, 1'b0, 1'b0, 32'h7800_0000, 32'h0000_0015}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !rxValid, "R1 reset flags", {29'd0, busy, done, rxValid}, 32'd0);
    chk(spiSclk == 1'b0, "R1 reset sclk idle", 32'(spiSclk), 32'd0);
    chk(spiCsN == 4'hF, "R1 reset cs all high", 32'(spiCsN), 32'hF);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // table walk: one word per vector
    for (int v = 0; v < 9; v++) begin
      logic [31:0] tx, mi, expRx, expTx;
      int len;
      bit lb;
      tx = VEC[v][63:32];
      mi = VEC[v][31:0];
      lb = VEC[v][64];
      len = int'(VEC[v][71:67]) + 1;
      setCfg(int'(VEC[v][71:67]), VEC[v][66], VEC[v][65], lb);
      slaveWord = lowBits(mi, len);
      expTx = topBits(tx, len);
      expRx = lb ? expTx : lowBits(mi, len);
      txMem[txPops & 3] = tx;
      txAvail = txPops + 1;
      kick(1);
      waitDone("R9 single word done");
      @(negedge clk);
      chk(rxN == 1 && rxLog[0] == expRx, "R2 R4 R6 received word", rxLog[0], expRx);
      chk(mosiN == 1 && mosiLog[0] == expTx, "R3 R4 R5 transmitted bits", mosiLog[0], expTx);
      chk(spiSclk == VEC[v][65], "R5 idle level after word", 32'(spiSclk), 32'(VEC[v][65]));
    end

    // R11: edge spacing with slower divider
    setCfg(7, 1'b1, 1'b0, 1'b1);
    clkDiv = 8'd3;
    txMem[txPops & 3] = 32'h3C00_0000;
    txAvail = txPops + 1;
    kick(1);
    waitDone("R11 transfer done");
    chk(e2 - e1 == 4, "R11 half period", 32'(e2 - e1), 32'd4);
    clkDiv = 8'd1;

    // R8: automatic chip select, R10/R9: stall between two words
    setCfg(7, 1'b0, 1'b0, 1'b1);
    csSel = 2'd2;
    chk(spiCsN == 4'hF, "R8 idle cs high", 32'(spiCsN), 32'hF);
    txMem[txPops & 3] = 32'h1100_0000;
    txAvail = txPops + 1;
    kick(2);
    repeat (4) @(negedge clk);
    chk(spiCsN == 4'b1011, "R8 selected line low", 32'(spiCsN), 32'hB);
    for (int i = 0; i < 200 && rxN < 1; i++) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(busy && rxN == 1 && doneN == 0, "R10 stalled waiting for word", 32'(rxN), 32'd1);
    chk(spiSclk == 1'b0 && edgeN == 16, "R10 no edges while stalled", 32'(edgeN), 32'd16);
    txMem[txPops & 3] = 32'h2200_0000;
    txAvail = txPops + 1;
    waitDone("R10 resume after stall");
    @(negedge clk);
    chk(rxN == 2 && rxLog[1] == 32'h22, "R10 R9 second word", rxLog[1], 32'h22);
    chk(!busy && doneN == 1, "R9 stops after count", 32'(busy), 32'd0);
    chk(spiCsN == 4'hF, "R8 cs released", 32'(spiCsN), 32'hF);

    // R7: forced chip select holds through a transfer
    csForce = 1'b1; csAssert = 4'b0101;
    @(negedge clk);
    chk(spiCsN == 4'b1010, "R7 forced cs idle", 32'(spiCsN), 32'hA);
    clearLogs();
    txMem[txPops & 3] = 32'h4400_0000;
    txAvail = txPops + 1;
    kick(1);
    repeat (6) @(negedge clk);
    chk(spiCsN == 4'b1010, "R7 forced cs busy", 32'(spiCsN), 32'hA);
    waitDone("R7 transfer done");
    csAuto = 1'b1;
    @(negedge clk);
    chk(spiCsN == 4'hF, "R8 auto overrides force", 32'(spiCsN), 32'hF);
    csAuto = 1'b0; csForce = 1'b0;

    // R9: zero count ignored
    clearLogs();
    kick(0);
    repeat (10) @(negedge clk);
    chk(!busy && doneN == 0 && edgeN == 0, "R9 zero count ignored", 32'(busy), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule